// File: doc/BRIEF.md
# Two-Level Descriptor Walking Copy Engine

This block is a memory-to-memory copy engine. A host starts it with one register write that gives the address of a list of pointers. The engine reads the pointers one after another. Each pointer leads to an array of commands, and each command is four words long. For every command the engine copies a run of 32-bit words from a source address to a destination address. While it copies, it can reorder the data at three scales: bytes inside halfwords, halfwords inside a word, and one word with the next. A flag in bit 31 ends each level: it marks the last pointer in the list and the last command in an array.

When a walk finishes, or when a command is found to be malformed, the engine pushes a result word into a small FIFO. The host pops that FIFO through a read-to-pop register. A status register shows how full the FIFO is and whether the engine can take a new start. An interrupt line stays high while the interrupt is enabled and the FIFO holds anything. All memory traffic goes through one word-wide port with a request/acknowledge handshake.

Top module: `dlist_walker`

## Requirements
- R1: After reset, status reads 0x00000001 (ready, FIFO empty), `irq` is low, `mem_req` is low, and a result read returns 0.
- R2: The start register (host address 0) takes list code 1 in bits 30:29 and a list address in bits 28:0, stored as the byte address divided by 8. Each list entry carries its array address in the same form, and bit 31 of the entry marks the last pointer. The pointers are walked in increasing address order.
- R3: A command is four words in the order control, source, destination, byte length. Bit 31 of the control word marks the last command of its array. The engine copies length/4 words from the source to the destination.
- R4: In the control word, bit 11 (source side) and bit 14 (destination side) exchange the bytes inside each halfword. Bit 12 and bit 15 exchange the two halfwords of each word. When both sides request the same swap, the two cancel.
- R5: Bit 13 (source side) and bit 16 (destination side) exchange each even-indexed word of the run with the word that follows it. When both are set, the exchanges cancel.
- R6: A command is rejected if its mode field (bits 1:0) is non-zero, if its length is not a multiple of 4, or if a word exchange is in effect and the length is not a multiple of 8. A start code other than 1 is also rejected. Any rejection posts 0x80000008 (0x8000000C when config bit 1 is set), and no further command of the walk runs.
- R7: A walk that completes posts one result, 0x80000002. With config bit 2 set, the engine posts 0x80000002 after every pointer's array instead.
- R8: Status (host address 2) holds the FIFO count in bits 31:29, the walk-in-progress count in bits 28:27, FIFO-not-empty in bit 1 and ready in bit 0.
- R9: Ready goes low at the start write and comes back high only once the final result is in the FIFO. A start write while the engine is busy has no effect.
- R10: A read of host address 1 returns the oldest result and removes it. A read of an empty FIFO returns 0 and changes nothing.
- R11: `irq` equals config bit 0 AND FIFO-not-empty. The config register is at host address 3.
- R12: While the FIFO is full, the engine holds its pending result and stays busy. No result is lost.
- R13: A command of length 0 makes no data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (pops on address 1) |
| host_addr | input | 2 | Register select: 0 start, 1 result, 2 status, 3 config |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational |
| irq | output | 1 | Interrupt: enabled and results pending |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |

## Verification
The bench sweeps all 64 combinations of the six swap bits over a four-word run and compares each destination word with a value it computes arithmetically. An engine that got the side composition wrong would double-apply or drop a swap, and one that exchanged the wrong beat of a pair would leave the words in place. A separate case writes a two-pointer list with a non-last command, to catch an engine that stops at the first array or ignores the last-pointer flag. The bench also runs malformed commands placed before valid ones, to catch an engine that reports an error and still runs the next command. It overfills the result FIFO in per-pointer mode, where a wrong engine would overwrite or drop results. Finally it sends a start while busy and runs a zero-length command; a wrong engine would restart the walk or write the destination anyway.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
   localparam logic [31:0] RES_DONE  = 32'h8000_0002;
   localparam logic [31:0] RES_ERR   = 32'h8000_0008;
   localparam logic [31:0] RES_FLUSH = 32'h0000_0004;
   localparam logic [1:0]  CODE_PTR_LIST = 2'd1;

   localparam int B_LAST = 31;
   localparam int B_SRC_BYTE = 11;
   localparam int B_SRC_HALF = 12;
   localparam int B_SRC_WORD = 13;
   localparam int B_DST_BYTE = 14;
   localparam int B_DST_HALF = 15;
   localparam int B_DST_WORD = 16;

   typedef enum logic [3:0] {
      S_IDLE, S_PTR, S_CMD, S_CHK, S_RDA, S_RDB, S_WRA, S_WRB, S_NEXT, S_POST
   } walk_st_t;

   typedef struct packed {
      logic       last;
      logic [1:0] mode;
      logic       sw_byte;
      logic       sw_half;
      logic       sw_word;
   } cmd_t;
endpackage

// File: rtl/dlw_lane_swap.sv
module dlw_lane_swap (
   input  logic [31:0] din,
   input  logic        sw_byte,
   input  logic        sw_half,
   output logic [31:0] dout
);
   logic [31:0] stage;

   for (genvar h = 0; h < 2; h++) begin : g_half
      assign stage[h*16 +: 16] = sw_byte ? {din[h*16 +: 8], din[h*16+8 +: 8]}
                                         : din[h*16 +: 16];
   end

   assign dout = sw_half ? {stage[15:0], stage[31:16]} : stage;
endmodule

// File: rtl/dlw_res_fifo.sv
module dlw_res_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 32,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic          full,
   output logic          empty,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wp, rp;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   wire do_push = push && !full;
   wire do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         count <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (do_push) begin
            mem_q[wp] <= din;
            wp <= bump(wp);
         end
         if (do_pop) rp <= bump(rp);
         if (do_push && !do_pop)      count <= count + CW'(1);
         else if (do_pop && !do_push) count <= count - CW'(1);
      end
   end

   assign dout  = empty ? '0 : mem_q[rp];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/dlw_walker.sv
module dlw_walker
   import dlw_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        start_code,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              cfg_flush,
   input  logic              cfg_top,
   input  logic              fifo_full,
   output logic              busy,
   output logic              post_valid,
   output logic [31:0]       post_word,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   walk_st_t          st;
   cmd_t              cmd;
   logic [ADDR_W-1:0] pptr, cptr, src, dst;
   logic [31:0]       len, bufa, bufb, res_q, rd_sw, ptr_byte;
   logic [1:0]        widx;
   logic              last_ptr, final_q;

   dlw_lane_swap u_swap (
      .din(mem_rdata), .sw_byte(cmd.sw_byte), .sw_half(cmd.sw_half), .dout(rd_sw)
   );

   assign ptr_byte = {mem_rdata[28:0], 3'b000};
   wire   len_bad  = (len[1:0] != 2'b00) || (cmd.sw_word && len[2]);
   wire   [31:0] err_word = RES_ERR | (cfg_flush ? RES_FLUSH : 32'h0);

   always_comb begin
      mem_req = 1'b0;
      mem_we = 1'b0;
      mem_addr = '0;
      mem_wdata = '0;
      unique case (st)
         S_PTR: begin mem_req = 1'b1; mem_addr = pptr; end
         S_CMD: begin mem_req = 1'b1; mem_addr = cptr + ADDR_W'({widx, 2'b00}); end
         S_RDA: begin mem_req = 1'b1; mem_addr = src; end
         S_RDB: begin mem_req = 1'b1; mem_addr = src + ADDR_W'(4); end
         S_WRA: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst;
            mem_wdata = cmd.sw_word ? bufb : bufa;
         end
         S_WRB: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = dst + ADDR_W'(4); mem_wdata = bufa;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE;
         cmd <= '0;
         pptr <= '0; cptr <= '0; src <= '0; dst <= '0;
         len <= '0; bufa <= '0; bufb <= '0; res_q <= '0;
         widx <= '0; last_ptr <= 1'b0; final_q <= 1'b0;
      end else begin
         unique case (st)
            S_IDLE: if (start) begin
               if (start_code == CODE_PTR_LIST) begin
                  pptr <= start_addr;
                  st <= S_PTR;
               end else begin
                  res_q <= err_word; final_q <= 1'b1; st <= S_POST;
               end
            end
            S_PTR: if (mem_ack) begin
               last_ptr <= mem_rdata[B_LAST];
               cptr <= ptr_byte[ADDR_W-1:0];
               pptr <= pptr + ADDR_W'(4);
               widx <= '0;
               st <= S_CMD;
            end
            S_CMD: if (mem_ack) begin
               unique case (widx)
                  2'd0: cmd <= '{last: mem_rdata[B_LAST], mode: mem_rdata[1:0],
                                 sw_byte: mem_rdata[B_SRC_BYTE] ^ mem_rdata[B_DST_BYTE],
                                 sw_half: mem_rdata[B_SRC_HALF] ^ mem_rdata[B_DST_HALF],
                                 sw_word: mem_rdata[B_SRC_WORD] ^ mem_rdata[B_DST_WORD]};
                  2'd1: src <= mem_rdata[ADDR_W-1:0];
                  2'd2: dst <= mem_rdata[ADDR_W-1:0];
                  default: len <= mem_rdata;
               endcase
               if (widx == 2'd3) begin
                  cptr <= cptr + ADDR_W'(16);
                  st <= S_CHK;
               end
               widx <= widx + 2'd1;
            end
            S_CHK: begin
               if (cmd.mode != 2'b00 || len_bad) begin
                  res_q <= err_word; final_q <= 1'b1; st <= S_POST;
               end else if (len == 32'd0) st <= S_NEXT;
               else st <= S_RDA;
            end
            S_RDA: if (mem_ack) begin
               bufa <= rd_sw;
               st <= cmd.sw_word ? S_RDB : S_WRA;
            end
            S_RDB: if (mem_ack) begin
               bufb <= rd_sw;
               st <= S_WRA;
            end
            S_WRA: if (mem_ack) begin
               if (cmd.sw_word) st <= S_WRB;
               else begin
                  src <= src + ADDR_W'(4);
                  dst <= dst + ADDR_W'(4);
                  len <= len - 32'd4;
                  st <= (len == 32'd4) ? S_NEXT : S_RDA;
               end
            end
            S_WRB: if (mem_ack) begin
               src <= src + ADDR_W'(8);
               dst <= dst + ADDR_W'(8);
               len <= len - 32'd8;
               st <= (len == 32'd8) ? S_NEXT : S_RDA;
            end
            S_NEXT: begin
               if (!cmd.last) begin
                  widx <= '0; st <= S_CMD;
               end else if (last_ptr) begin
                  res_q <= RES_DONE; final_q <= 1'b1; st <= S_POST;
               end else if (cfg_top) begin
                  res_q <= RES_DONE; final_q <= 1'b0; st <= S_POST;
               end else st <= S_PTR;
            end
            S_POST: if (!fifo_full) st <= final_q ? S_IDLE : S_PTR;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy       = (st != S_IDLE);
   assign post_valid = (st == S_POST) && !fifo_full;
   assign post_word  = res_q;
endmodule

// File: rtl/dlist_walker.sv
module dlist_walker #(
   parameter int ADDR_W    = 16,
   parameter int RES_DEPTH = 4,
   localparam int CW       = $clog2(RES_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata
);
   if (RES_DEPTH < 1 || RES_DEPTH > 7) begin : g_bad_depth
      $error("RES_DEPTH must lie in 1..7 to fit the 3-bit status count");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 8..32");
   end

   logic [2:0]    cfg_q;
   logic [CW-1:0] res_count;
   logic [2:0]    cnt3;
   logic [31:0]   res_head, post_word, start_byte, status;
   logic          busy, post_valid, fifo_full, fifo_empty, unused_bits;

   wire start_wr = host_wr && (host_addr == 2'd0) && !busy;
   wire pop_rd   = host_rd && (host_addr == 2'd1);

   assign start_byte  = {host_wdata[28:0], 3'b000};
   assign unused_bits = ^{host_wdata[31], start_byte};

   if (CW >= 3) begin : g_cnt_full
      assign cnt3 = res_count[2:0];
   end else begin : g_cnt_pad
      assign cnt3 = {{(3 - CW){1'b0}}, res_count};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q <= '0;
      else if (host_wr && host_addr == 2'd3) cfg_q <= host_wdata[2:0];
   end

   dlw_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start_wr),
      .start_code(host_wdata[30:29]), .start_addr(start_byte[ADDR_W-1:0]),
      .cfg_flush(cfg_q[1]), .cfg_top(cfg_q[2]), .fifo_full(fifo_full),
      .busy(busy), .post_valid(post_valid), .post_word(post_word),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   dlw_res_fifo #(.DEPTH(RES_DEPTH), .W(32)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(post_valid), .din(post_word),
      .pop(pop_rd), .dout(res_head), .full(fifo_full), .empty(fifo_empty),
      .count(res_count)
   );

   assign status = {cnt3, 1'b0, busy, 25'd0, !fifo_empty, !busy};

   always_comb begin
      unique case (host_addr)
         2'd1:    host_rdata = res_head;
         2'd2:    host_rdata = status;
         2'd3:    host_rdata = {29'd0, cfg_q};
         default: host_rdata = 32'd0;
      endcase
   end

   assign irq = cfg_q[0] && !fifo_empty;
endmodule

// File: rtl/dlw_checker.sv
module dlw_checker #(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 4,
   parameter int CW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [1:0]        host_addr,
   input logic              irq,
   input logic              busy,
   input logic              post_valid,
   input logic [CW-1:0]     res_count,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd0 && !busy) |=> busy);

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_irq_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (res_count != '0));

   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      res_count <= CW'(DEPTH));

   p_full_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (res_count == CW'(DEPTH)) |-> !post_valid);

   p_pop_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_addr == 2'd1 && res_count != '0 && !post_valid)
      |=> (res_count == $past(res_count) - CW'(1)));
endmodule

bind dlist_walker dlw_checker #(.ADDR_W(ADDR_W), .DEPTH(RES_DEPTH), .CW(CW)) u_dlw_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_addr(host_addr), .irq(irq), .busy(busy), .post_valid(post_valid),
   .res_count(res_count), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/dlist_walker_bench.sv
`timescale 1ns/1ps
module dlist_walker_bench;
   localparam int AW = 12;
   localparam logic [31:0] SENT = 32'hDEAD_BEEF;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [31:0] host_wdata = 32'd0, host_rdata;
   logic irq, mem_req, mem_we, mem_ack = 1'b0;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata = 32'd0;
   logic [31:0] mem [1024];

   int checks = 0, failures = 0;

   always #5 clk = ~clk;

   dlist_walker #(.ADDR_W(AW), .RES_DEPTH(4)) u_dlist_walker (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // memory model: answers a request on the falling edge, one access per two cycles
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (mem_we) mem[mem_addr[AW-1:2]] = mem_wdata;
            else mem_rdata = mem[mem_addr[AW-1:2]];
            mem_ack = 1'b1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      host_rd = (a != 2'd0); host_addr = a;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic wait_ready();
      logic [31:0] s;
      for (int i = 0; i < 4000; i++) begin
         hread(2'd2, s);
         if (s[0]) return;
      end
      check("R9 ready timeout", 32'd0, 32'd1);
   endtask

   function automatic logic [31:0] start_w(input int addr, input int code);
      return (32'(code) << 29) | (32'(addr) >> 3);
   endfunction

   function automatic logic [31:0] ptr_w(input int arr, input bit last);
      return ({last, 31'd0}) | (32'(arr) >> 3);
   endfunction

   task automatic put_cmd(input int arr, input int idx, input logic [31:0] c,
                          input int s, input int d, input int l);
      int b = (arr + idx * 16) >> 2;
      mem[b] = c; mem[b+1] = 32'(s); mem[b+2] = 32'(d); mem[b+3] = 32'(l);
   endtask

   task automatic fill(input int addr, input int n, input logic [31:0] v);
      for (int i = 0; i < n; i++) mem[(addr >> 2) + i] = v;
   endtask

   function automatic logic [31:0] bsw(input logic [31:0] v);
      return ((v & 32'h00FF_00FF) << 8) | ((v >> 8) & 32'h00FF_00FF);
   endfunction

   function automatic logic [31:0] hsw(input logic [31:0] v);
      return (v << 16) | (v >> 16);
   endfunction

   logic [31:0] rd;
   bit wd_hit = 1'b0;

   initial begin
      #1_500_000;
      wd_hit = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hread(2'd2, rd); check("R1 status", rd, 32'h0000_0001);
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 mem_req", {31'd0, mem_req}, 32'd0);
      hread(2'd1, rd); check("R1 R10 empty result read", rd, 32'd0);

      // R4 R5 sweep of every swap-bit combination over a 16-byte run
      for (int c = 0; c < 64; c++) begin
         logic [31:0] src_v [4];
         logic [31:0] cw, e;
         bit ws, bs, hs;
         for (int i = 0; i < 4; i++) begin
            src_v[i] = (32'h0A0B_0C0D * 32'(i + 1)) ^ 32'(c * 32'h0101);
            mem[(12'h400 >> 2) + i] = src_v[i];
         end
         fill(12'h600, 5, SENT);
         cw = 32'h8000_0000 | (32'(c & 7) << 11) | (32'((c >> 3) & 7) << 14);
         put_cmd(12'h100, 0, cw, 12'h400, 12'h600, 16);
         mem[12'h080 >> 2] = ptr_w(12'h100, 1'b1);
         hwrite(2'd0, start_w(12'h080, 1));
         wait_ready();
         bs = c[0] ^ c[3]; hs = c[1] ^ c[4]; ws = c[2] ^ c[5];
         for (int i = 0; i < 4; i++) begin
            e = src_v[ws ? (i ^ 1) : i];
            if (bs) e = bsw(e);
            if (hs) e = hsw(e);
            check(ws ? "R5 word pair swap" : "R4 lane swap", mem[(12'h600 >> 2) + i], e);
         end
         check("R3 copy bound", mem[(12'h600 >> 2) + 4], SENT);
         hread(2'd1, rd); check("R7 done result", rd, 32'h8000_0002);
      end
      hread(2'd2, rd); check("R8 status idle after pops", rd, 32'h0000_0001);

      // R2 R3 R8 two pointers, first array holds two commands
      for (int i = 0; i < 8; i++) mem[(12'h400 >> 2) + i] = 32'h1000_0000 + 32'(i * 17);
      fill(12'h600, 24, SENT);
      put_cmd(12'h100, 0, 32'h0000_0000, 12'h400, 12'h600, 8);
      put_cmd(12'h100, 1, 32'h8000_1000, 12'h408, 12'h620, 4);
      put_cmd(12'h140, 0, 32'h8001_0000, 12'h410, 12'h640, 8);
      mem[12'h080 >> 2] = ptr_w(12'h100, 1'b0);
      mem[12'h084 >> 2] = ptr_w(12'h140, 1'b1);
      hwrite(2'd0, start_w(12'h080, 1));
      hread(2'd2, rd); check("R8 R9 busy status", rd, 32'h0800_0000);
      wait_ready();
      check("R3 cmd0 w0", mem[12'h600 >> 2], 32'h1000_0000);
      check("R3 cmd0 w1", mem[(12'h600 >> 2) + 1], 32'h1000_0011);
      check("R3 cmd0 bound", mem[(12'h600 >> 2) + 2], SENT);
      check("R4 cmd1 half swap", mem[12'h620 >> 2], hsw(32'h1000_0022));
      check("R2 second pointer w0", mem[12'h640 >> 2], 32'h1000_0055);
      check("R2 R5 second pointer w1", mem[(12'h640 >> 2) + 1], 32'h1000_0044);
      hread(2'd2, rd); check("R8 one result pending", rd, 32'h2000_0003);
      hread(2'd1, rd); check("R7 single result", rd, 32'h8000_0002);
      hread(2'd2, rd); check("R10 pop empties", rd, 32'h0000_0001);

      // R7 R11 per-pointer results with interrupt enabled
      hwrite(2'd3, 32'h5);
      hwrite(2'd0, start_w(12'h080, 1));
      wait_ready();
      hread(2'd2, rd); check("R7 two results", rd, 32'h4000_0003);
      check("R11 irq high", {31'd0, irq}, 32'd1);
      hread(2'd1, rd); check("R7 ptr0 result", rd, 32'h8000_0002);
      hread(2'd1, rd); check("R7 ptr1 result", rd, 32'h8000_0002);
      check("R11 irq low when empty", {31'd0, irq}, 32'd0);
      hread(2'd1, rd); check("R10 empty pop", rd, 32'd0);
      hread(2'd2, rd); check("R10 empty pop no change", rd, 32'h0000_0001);

      // R6 bad mode: following command must not run
      hwrite(2'd3, 32'h0);
      fill(12'h600, 24, SENT);
      put_cmd(12'h100, 0, 32'h0000_0001, 12'h400, 12'h600, 4);
      put_cmd(12'h100, 1, 32'h8000_0000, 12'h400, 12'h620, 4);
      mem[12'h080 >> 2] = ptr_w(12'h100, 1'b1);
      hwrite(2'd0, start_w(12'h080, 1));
      wait_ready();
      hread(2'd1, rd); check("R6 mode error", rd, 32'h8000_0008);
      check("R6 no copy for bad cmd", mem[12'h600 >> 2], SENT);
      check("R6 later cmd skipped", mem[12'h620 >> 2], SENT);
      check("R11 irq off when disabled", {31'd0, irq}, 32'd0);

      // R6 misaligned length with flush flag
      hwrite(2'd3, 32'h2);
      put_cmd(12'h100, 0, 32'h8000_0000, 12'h400, 12'h600, 6);
      hwrite(2'd0, start_w(12'h080, 1));
      wait_ready();
      hread(2'd1, rd); check("R6 misaligned with flush", rd, 32'h8000_000C);

      // R6 word exchange with length 12
      hwrite(2'd3, 32'h0);
      put_cmd(12'h100, 0, 32'h8000_2000, 12'h400, 12'h600, 12);
      hwrite(2'd0, start_w(12'h080, 1));
      wait_ready();
      hread(2'd1, rd); check("R6 word swap length", rd, 32'h8000_0008);
      check("R6 no partial copy", mem[12'h600 >> 2], SENT);

      // R6 bad start code
      hwrite(2'd0, start_w(12'h080, 0));
      wait_ready();
      hread(2'd1, rd); check("R6 bad start code", rd, 32'h8000_0008);

      // R13 zero length, then a normal command
      put_cmd(12'h100, 0, 32'h0000_0000, 12'h400, 12'h600, 0);
      put_cmd(12'h100, 1, 32'h8000_0000, 12'h404, 12'h620, 4);
      hwrite(2'd0, start_w(12'h080, 1));
      wait_ready();
      check("R13 zero length untouched", mem[12'h600 >> 2], SENT);
      check("R13 next cmd runs", mem[12'h620 >> 2], 32'h1000_0011);
      hread(2'd1, rd); check("R13 result", rd, 32'h8000_0002);

      // R9 start while busy is ignored
      fill(12'h600, 24, SENT);
      put_cmd(12'h100, 0, 32'h8000_0000, 12'h400, 12'h600, 32);
      put_cmd(12'h140, 0, 32'h8000_0000, 12'h400, 12'h640, 4);
      mem[12'h088 >> 2] = ptr_w(12'h140, 1'b1);
      hwrite(2'd0, start_w(12'h080, 1));
      hwrite(2'd0, start_w(12'h088, 1));
      wait_ready();
      check("R9 second start ignored", mem[12'h640 >> 2], SENT);
      check("R9 first walk ran", mem[(12'h600 >> 2) + 7], 32'h1000_0077);
      hread(2'd2, rd); check("R9 one result only", rd, 32'h2000_0003);
      hread(2'd1, rd);

      // R12 six per-pointer results into a four-entry FIFO
      hwrite(2'd3, 32'h4);
      for (int k = 0; k < 6; k++) begin
         mem[(12'h080 >> 2) + k] = ptr_w(12'h100 + k * 32, k == 5);
         put_cmd(12'h100 + k * 32, 0, 32'h8000_0000, 12'h400, 12'h600, 0);
      end
      hwrite(2'd0, start_w(12'h080, 1));
      repeat (300) @(negedge clk);
      hread(2'd2, rd); check("R12 full and held busy", rd, 32'h8800_0002);
      for (int k = 0; k < 4; k++) begin
         hread(2'd1, rd); check("R12 early result", rd, 32'h8000_0002);
      end
      wait_ready();
      hread(2'd2, rd); check("R12 remaining two", rd, 32'h4000_0003);
      for (int k = 0; k < 2; k++) begin
         hread(2'd1, rd); check("R12 late result", rd, 32'h8000_0002);
      end
      hread(2'd2, rd); check("R12 drained", rd, 32'h0000_0001);

      if (!wd_hit) begin
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule